// File: doc/BRIEF.md
# Shift-and-Add Rotating Down-Mixer

This block turns a stream of real samples into complex baseband samples. A phase accumulator, advanced by a programmable tuning word, supplies a rotation angle for every accepted sample. An unrolled rotation pipeline then turns the real sample, taken as the vector (x, 0), by the negative of that angle. The oscillator and the mixing product come out of the same shift-and-add datapath, so the block needs no sine table and no multiplier.

The pipeline takes one new sample on every clock. Each sample is rotated by the accumulator value that existed before that sample arrived. The rotation gain of the iterations, about 1.6468 for 18 stages, is not corrected. The outputs are one bit wider than the input to hold it. A downstream filter or scaler is expected to absorb the gain.

Top module: `rot_mixer`

## Requirements
- R1: While reset is asserted, and until the first result appears, `out_vld` is 0 and `out_i`/`out_q` are 0.
- R2: A sample accepted at a rising edge with `in_vld` high appears with `out_vld` high exactly NITER+1 rising edges later (19 with defaults). Samples on consecutive clocks give results on consecutive clocks, in order.
- R3: For input x and angle θ, `out_i` equals G·x·cos θ and `out_q` equals −G·x·sin θ within 3 LSB, where G = Π√(1+2^(−2i)) over the NITER stages.
- R4: θ is the upper ANG_W bits of a PHASE_W-bit accumulator, read as a fraction of a full turn. The accumulator starts at 0 after reset and adds `ftw` only at an edge where `in_vld` is high. The first sample after reset uses θ = 0.
- R5: Angles in every quadrant, including exactly 90°, 180° and 270°, give results within the R3 tolerance.
- R6: Full-scale inputs (−2^(DW−1) and 2^(DW−1)−1) do not wrap. |out| stays below 1.6875·2^(DW−1).
- R7: The `ftw` sampled together with a sample sets the phase of the next sample. Changing `ftw` on every sample takes effect one sample later.
- R8: With `ftw` = 0 the output is I = G·x and Q = 0, which shows that the gain is left uncorrected.
- R9: Cycles with `in_vld` low produce no result and do not move the phase. Data and tuning word values on such cycles have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Input sample strobe |
| in_smp | input | DW (16) | Signed real input sample |
| ftw | input | PHASE_W (32) | Frequency tuning word, a phase step per accepted sample |
| out_vld | output | 1 | Output strobe |
| out_i | output | DW+1 (17) | Signed in-phase result |
| out_q | output | DW+1 (17) | Signed quadrature result |

## Verification
Every result is due NITER+1 rising edges after the edge that sampled its input: one fold stage, NITER rotation stages and one output register. The bench keeps its own phase model and pushes the expected I/Q pair, together with the edge count, at each edge that samples `in_vld` high. It pops one entry at each falling edge where `out_vld` is high and requires the recorded edge count to be exactly NITER+2 lower than the current one. Any `out_vld` with nothing pending, and any count mismatch, is reported against R9 or R2.

// File: rtl/rot_mixer_pkg.sv
package rot_mixer_pkg;

  // arctan(2^-idx) expressed as a fraction of a full turn, scaled by 2^32
  function automatic logic [31:0] atan_turn32(input int idx);
    case (idx)
      0:  return 32'd536870912;
      1:  return 32'd316933406;
      2:  return 32'd167458907;
      3:  return 32'd85004756;
      4:  return 32'd42667331;
      5:  return 32'd21354465;
      6:  return 32'd10679838;
      7:  return 32'd5340245;
      8:  return 32'd2670163;
      9:  return 32'd1335087;
      10: return 32'd667544;
      11: return 32'd333772;
      12: return 32'd166886;
      13: return 32'd83443;
      14: return 32'd41722;
      15: return 32'd20861;
      16: return 32'd10430;
      17: return 32'd5215;
      // beyond this, arctan(2^-i) ~ 2^-i to well below one LSB
      default: return 32'd683565276 >> idx;
    endcase
  endfunction

  // rounded to an angle word of aw bits (aw < 32)
  function automatic logic [31:0] atan_scaled(input int idx, input int aw);
    logic [32:0] t;
    t = {1'b0, atan_turn32(idx)} + (33'd1 << (31 - aw));
    return 32'(t >> (32 - aw));
  endfunction

endpackage

// File: rtl/rot_rst_sync.sv
module rot_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/rot_phase_acc.sv
module rot_phase_acc #(
  parameter int PHASE_W = 32,
  parameter int ANG_W   = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [PHASE_W-1:0] ftw,
  output logic [ANG_W-1:0]   angle
);
  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W-1:0] acc_d;

  always_comb begin
    acc_d = acc_q;
    if (en) acc_d = acc_q + ftw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign angle = acc_q[PHASE_W-1 -: ANG_W];

  // R9: no accepted sample, no phase movement
  p_acc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(angle));
endmodule

// File: rtl/rot_prefold.sv
module rot_prefold #(
  parameter int DW    = 16,
  parameter int GUARD = 2,
  parameter int ANG_W = 24,
  localparam int W    = DW + 1 + GUARD
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                vld_o,
  input  logic [DW-1:0]       smp,
  input  logic [ANG_W-1:0]    angle,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o,
  output logic [ANG_W-1:0]    z_o
);
  logic [ANG_W-1:0]    phi;
  logic                flip;
  logic signed [W-1:0] x_ext;
  logic signed [W-1:0] x_d;
  logic [ANG_W-1:0]    z_d;

  always_comb begin
    phi   = -angle;                          // down-mixing: rotate by -theta
    flip  = phi[ANG_W-1] ^ phi[ANG_W-2];     // second or third quadrant
    x_ext = {{(W-DW-GUARD){smp[DW-1]}}, smp, {GUARD{1'b0}}};
    x_d   = flip ? -x_ext : x_ext;
    z_d   = flip ? (phi ^ {1'b1, {(ANG_W-1){1'b0}}}) : phi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_o <= '0;
      y_o <= '0;
      z_o <= '0;
    end else if (en) begin
      x_o <= x_d;
      y_o <= '0;
      z_o <= z_d;
    end
  end

  // R5: after folding the residual angle lies in [-90, +90)
  p_fold_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (z_o[ANG_W-1] == z_o[ANG_W-2]));
endmodule

// File: rtl/rot_valid_pipe.sv
module rot_valid_pipe #(
  parameter int DEPTH = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  output logic [DEPTH-1:0] vld_q
);
  logic [DEPTH-1:0] vld_d;

  always_comb begin
    vld_d = {vld_q[DEPTH-2:0], in_vld};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end
endmodule

// File: rtl/rot_cordic_stage.sv
module rot_cordic_stage
  import rot_mixer_pkg::*;
#(
  parameter int W     = 19,
  parameter int ANG_W = 24,
  parameter int IDX   = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                vld_o,
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] y_i,
  input  logic [ANG_W-1:0]    z_i,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o,
  output logic [ANG_W-1:0]    z_o
);
  localparam logic [ANG_W-1:0] ATAN = ANG_W'(atan_scaled(IDX, ANG_W));
  localparam logic [ANG_W-1:0] ZLIM = ATAN + ANG_W'(IDX + 2);

  logic signed [W-1:0] x_sh;
  logic signed [W-1:0] y_sh;
  logic signed [W-1:0] x_d;
  logic signed [W-1:0] y_d;
  logic [ANG_W-1:0]    z_d;

  always_comb begin
    x_sh = x_i >>> IDX;
    y_sh = y_i >>> IDX;
    if (!z_i[ANG_W-1]) begin
      x_d = x_i - y_sh;
      y_d = y_i + x_sh;
      z_d = z_i - ATAN;
    end else begin
      x_d = x_i + y_sh;
      y_d = y_i - x_sh;
      z_d = z_i + ATAN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_o <= '0;
      y_o <= '0;
      z_o <= '0;
    end else if (en) begin
      x_o <= x_d;
      y_o <= y_d;
      z_o <= z_d;
    end
  end

  logic [ANG_W-1:0] z_abs;
  always_comb z_abs = z_o[ANG_W-1] ? -z_o : z_o;

  // R3: residual angle shrinks to within this stage's arctan step
  p_residual_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (z_abs <= ZLIM));

  // R9: stage contents hold when no sample moves through
  p_stage_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(x_o) && $stable(y_o)));
endmodule

// File: rtl/rot_mixer.sv
module rot_mixer #(
  parameter int DW      = 16,
  parameter int PHASE_W = 32,
  parameter int ANG_W   = 24,
  parameter int NITER   = 18,
  parameter int GUARD   = 2,
  localparam int OW     = DW + 1,
  localparam int W      = DW + 1 + GUARD,
  localparam int DEPTH  = NITER + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_vld,
  input  logic [DW-1:0]         in_smp,
  input  logic [PHASE_W-1:0]    ftw,
  output logic                  out_vld,
  output logic signed [OW-1:0]  out_i,
  output logic signed [OW-1:0]  out_q
);
  logic rst_n_s;
  logic [ANG_W-1:0] angle;
  logic [DEPTH-1:0] vld_q;

  logic signed [W-1:0] xs [0:NITER];
  logic signed [W-1:0] ys [0:NITER];
  logic [ANG_W-1:0]    zs [0:NITER];

  rot_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  rot_phase_acc #(.PHASE_W(PHASE_W), .ANG_W(ANG_W)) u_acc (
    .clk(clk), .rst_n(rst_n_s), .en(in_vld), .ftw(ftw), .angle(angle)
  );

  rot_valid_pipe #(.DEPTH(DEPTH)) u_vld (
    .clk(clk), .rst_n(rst_n_s), .in_vld(in_vld), .vld_q(vld_q)
  );

  rot_prefold #(.DW(DW), .GUARD(GUARD), .ANG_W(ANG_W)) u_fold (
    .clk(clk), .rst_n(rst_n_s), .en(in_vld), .vld_o(vld_q[0]),
    .smp(in_smp), .angle(angle),
    .x_o(xs[0]), .y_o(ys[0]), .z_o(zs[0])
  );

  for (genvar k = 0; k < NITER; k++) begin : g_stage
    rot_cordic_stage #(.W(W), .ANG_W(ANG_W), .IDX(k)) u_st (
      .clk(clk), .rst_n(rst_n_s), .en(vld_q[k]), .vld_o(vld_q[k+1]),
      .x_i(xs[k]), .y_i(ys[k]), .z_i(zs[k]),
      .x_o(xs[k+1]), .y_o(ys[k+1]), .z_o(zs[k+1])
    );
  end

  logic signed [OW-1:0] oi_d;
  logic signed [OW-1:0] oq_d;
  logic signed [OW-1:0] oi_q;
  logic signed [OW-1:0] oq_q;

  always_comb begin
    oi_d = oi_q;
    oq_d = oq_q;
    if (vld_q[NITER]) begin
      oi_d = xs[NITER][W-1:GUARD];
      oq_d = ys[NITER][W-1:GUARD];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      oi_q <= '0;
      oq_q <= '0;
    end else begin
      oi_q <= oi_d;
      oq_q <= oq_d;
    end
  end

  assign out_vld = vld_q[NITER+1];
  assign out_i   = oi_q;
  assign out_q   = oq_q;

  logic unused_tail;
  assign unused_tail = ^{zs[NITER], xs[NITER][GUARD-1:0], ys[NITER][GUARD-1:0]};

  // R6: gain growth never reaches the output word limit
  localparam int MAG_LIM = ((2 ** (DW - 1)) * 27) / 16;
  logic [OW-1:0] abs_i;
  logic [OW-1:0] abs_q;
  always_comb begin
    abs_i = out_i[OW-1] ? -out_i : out_i;
    abs_q = out_q[OW-1] ? -out_q : out_q;
  end
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    out_vld |-> (abs_i < OW'(MAG_LIM) && abs_q < OW'(MAG_LIM)));
endmodule

// File: tb/tb_rot_mixer.sv
module tb_rot_mixer;
  localparam int DW = 16, PHASE_W = 32, ANG_W = 24, NITER = 18, GUARD = 2;
  localparam int OW = DW + 1;
  localparam real TWO_PI = 6.283185307179586;
  localparam real TOL = 3.0;

  logic clk = 0;
  logic rst_n = 0;
  logic in_vld = 0;
  logic [DW-1:0] in_smp = '0;
  logic [PHASE_W-1:0] ftw = '0;
  logic out_vld;
  logic signed [OW-1:0] out_i, out_q;

  rot_mixer #(.DW(DW), .PHASE_W(PHASE_W), .ANG_W(ANG_W), .NITER(NITER), .GUARD(GUARD)) dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_smp(in_smp), .ftw(ftw),
    .out_vld(out_vld), .out_i(out_i), .out_q(out_q)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit live = 0;
  bit done = 0;
  logic [PHASE_W-1:0] acc_m = '0;
  real    q_i[$];
  real    q_q[$];
  int     q_c[$];
  string  q_tag[$];
  string  cur_tag = "R3";

  function automatic real gain();
    real g = 1.0;
    for (int i = 0; i < NITER; i++) g = g * $sqrt(1.0 + 2.0 ** (-2.0 * i));
    return g;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0f expected %0f", req, what, act, exp);
    end
  endtask

  // model: samples inputs at the same edge as the design
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (live && in_vld) begin
      real th, x;
      th = real'(acc_m[PHASE_W-1 -: ANG_W]) / (2.0 ** ANG_W) * TWO_PI;
      x  = real'($signed(in_smp));
      q_i.push_back(gain() * x * $cos(th));
      q_q.push_back(-gain() * x * $sin(th));
      q_c.push_back(cyc);
      q_tag.push_back(cur_tag);
      acc_m <= acc_m + ftw;
    end
  end

  // monitor away from the active edge
  always @(negedge clk) begin
    if (!live) begin
      if (cyc > 1) begin
        check(out_vld == 1'b0, "R1", "out_vld in reset", real'(out_vld), 0.0);
        check(out_i == 0 && out_q == 0, "R1", "outputs in reset", real'(out_i), 0.0);
      end
    end else if (out_vld) begin
      if (q_i.size() == 0) begin
        check(1'b0, "R9", "unexpected out_vld", 1.0, 0.0);
      end else begin
        real ei, eq;
        int c0;
        string tg;
        ei = q_i.pop_front(); eq = q_q.pop_front();
        c0 = q_c.pop_front(); tg = q_tag.pop_front();
        check(cyc - c0 == NITER + 2, "R2", "latency", real'(cyc - c0), real'(NITER + 2));
        check((real'(out_i) - ei) <= TOL && (ei - real'(out_i)) <= TOL, tg, "I", real'(out_i), ei);
        check((real'(out_q) - eq) <= TOL && (eq - real'(out_q)) <= TOL, tg, "Q", real'(out_q), eq);
      end
    end
  end

  task automatic drive(input bit v, input int x, input logic [PHASE_W-1:0] f);
    @(negedge clk);
    in_vld = v;
    in_smp = DW'(x);
    ftw    = f;
  endtask

  task automatic drain();
    drive(0, 0, ftw);
    repeat (NITER + 6) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd4242);
    // R1: inputs toggling under reset are ignored
    in_vld = 1; in_smp = 16'h1234; ftw = 32'h1000_0000;
    repeat (6) @(negedge clk);
    rst_n = 1;
    in_vld = 0;
    repeat (4) @(negedge clk);
    check(out_vld == 0 && out_i == 0, "R1", "after release", real'(out_i), 0.0);
    live = 1;

    // R8: zero tuning word shows the raw gain
    cur_tag = "R8";
    for (int k = 0; k < 4; k++) drive(1, 1000, 32'd0);
    drain();

    // R5: quadrant boundaries, 90 degree steps
    cur_tag = "R5";
    for (int k = 0; k < 8; k++) drive(1, 20000, 32'h4000_0000);
    for (int k = 0; k < 8; k++) drive(1, -12345, 32'h2000_0000);
    drain();

    // R6: full scale both signs, odd-eighth angles
    cur_tag = "R6";
    for (int k = 0; k < 8; k++) drive(1, -32768, 32'h2000_0000);
    for (int k = 0; k < 8; k++) drive(1, 32767, 32'h1555_5555);
    drain();

    // R7: tuning word alternating every sample
    cur_tag = "R7";
    for (int k = 0; k < 12; k++) drive(1, 15000, (k % 2) ? 32'h0100_0000 : 32'h3000_0000);
    drain();

    // R9: idle cycles with busy data and tuning word must not move phase
    cur_tag = "R9";
    for (int k = 0; k < 30; k++) drive(0, int'($urandom()), $urandom());
    check(out_vld == 0, "R9", "idle output", real'(out_vld), 0.0);
    for (int k = 0; k < 4; k++) drive(1, 9000, 32'h0800_0000);
    drain();

    // R2/R3/R4: random stream with gaps and tuning word changes
    cur_tag = "R3";
    begin
      logic [PHASE_W-1:0] f;
      f = $urandom();
      for (int k = 0; k < 600; k++) begin
        if ($urandom_range(0, 19) == 0) f = $urandom();
        drive(($urandom_range(0, 9) < 7), int'($signed(16'($urandom()))), f);
      end
    end
    drain();

    // R2: long back-to-back burst
    cur_tag = "R4";
    for (int k = 0; k < 100; k++) drive(1, int'($signed(16'($urandom()))), 32'h0123_4567);
    drain();

    check(q_i.size() == 0, "R2", "results outstanding", real'(q_i.size()), 0.0);
    finish_run();
  end
endmodule